// File: doc/BRIEF.md
# Descriptor-Chained Receive DMA Channel

This block is one receive channel of a frame DMA engine. Software places a chain of descriptors in memory. Each descriptor starts with a 64-bit link word and a 64-bit control word. These are followed by up to fifteen slots, and each slot pairs a 64-bit buffer address with a 64-bit completion word. The channel follows the chain and stores incoming frame beats into the slot buffers. After each buffer it writes a completion word back to memory, so software can tell which buffers hold finished data.

A frame that does not fit in one buffer continues in the next slot. A link word with its lowest bit set ends the chain, and the channel parks there. Software can then append a descriptor, rewrite the link word and issue a reload. The channel reads the link word again and resumes. While no buffer is available, the frame input is held off rather than dropped.

All memory traffic goes through one request/grant port. Reads return their data with a separate valid strobe.

Top module: `rxd_chan`

## Requirements
- R1: While reset is held, and in the first cycle after it, mem_req, in_ready, irq and ch_active are all low.
- R2: The head address is built from head_wdata as two 32-bit halves: head_lo_we loads bits 31:0 and head_hi_we loads bits 63:32. On ch_activate from idle, the first memory request is a read at head + 8, which fetches the control word.
- R3: The buffer address of slot i is read from descriptor + 16 + 16*i. Each accepted 8-byte beat is written to that buffer address + 8*k, where k is the beat's index within the buffer, and the write carries the beat's data unchanged.
- R4: The completion word of slot i is written to descriptor + 24 + 16*i. Its bits are: byte length in 15:0, frame start in 16, frame end in 17, interrupt in 18, done (always 1) in 19, and block offset in 31:20 (always 0).
- R5: A buffer holds floor(L/8) beats, where L is control-word bits 15:0. A frame longer than that continues in the following slot. The frame-start bit is set only in the buffer that holds the first beat, and the frame-end bit only in the buffer that holds the last beat.
- R6: Only the first cfg_bufs slots of each descriptor are used. A value of 0 counts as 1, and values above 15 count as 15. After the last used slot, the link word at descriptor + 0 is read, and a link with bit 0 clear becomes the next descriptor.
- R7: A link word with bit 0 set makes the channel stall. While stalled, ch_stalled is high and no memory request is issued.
- R8: ch_reload while stalled re-reads the same link word. The channel continues if that word is now valid and stalls again if it is not.
- R9: While no buffer has space, in_ready stays low. No beat is lost, and a held beat lands in the next buffer that becomes available.
- R10: irq pulses for one cycle after a completion word is written with its interrupt bit set. That bit is control-word bit 18, further gated when cfg_eof_irq_only is high so that only buffers carrying frame end set it.
- R11: ch_stop is honoured at a frame boundary, or at once while stalled. The channel then goes idle: ch_active is low and no memory request or input acceptance follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| head_lo_we | input | 1 | Load low half of chain head |
| head_hi_we | input | 1 | Load high half of chain head |
| head_wdata | input | 32 | Chain head half-word |
| cfg_bufs | input | 4 | Slots used per descriptor |
| cfg_eof_irq_only | input | 1 | Restrict interrupts to frame-end buffers |
| ch_activate | input | 1 | Start the channel from idle |
| ch_reload | input | 1 | Re-read link word when stalled |
| ch_stop | input | 1 | Request return to idle |
| ch_active | output | 1 | Channel not idle |
| ch_stalled | output | 1 | Parked at end of chain |
| in_valid | input | 1 | Frame beat valid |
| in_ready | output | 1 | Frame beat accepted this cycle |
| in_data | input | 64 | Frame beat (8 bytes) |
| in_sof | input | 1 | Beat is first of frame |
| in_eof | input | 1 | Beat is last of frame |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 64 | Write data |
| mem_gnt | input | 1 | Request granted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| irq | output | 1 | Buffer interrupt pulse |

## Verification
The hardest situation to reach from the ports is a frame that runs past the end of the chain. Its first part is already committed to memory and its tail is held off at the input. Software then extends the chain and issues a reload. The stimulus sets up a single descriptor whose link is terminated and sends a frame longer than the remaining slot, with grants given only every other cycle. While the channel is parked, it issues one reload before the link is fixed and one after. It then checks that the held beats land at the start of the new descriptor's first buffer, with frame end and no frame start.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RINFO, ST_RPTR, ST_DATA, ST_WR, ST_STAT, ST_RNEXT, ST_STALL
  } rxd_state_e;

  localparam int LEN_W        = 16;
  localparam int INFO_IRQ_BIT = 18;
  localparam int ST_SOF_BIT   = 16;
  localparam int ST_EOF_BIT   = 17;
  localparam int ST_IRQ_BIT   = 18;
  localparam int ST_DONE_BIT  = 19;
  localparam int OFS_INFO     = 8;
  localparam int OFS_SLOT0    = 16;
  localparam int SLOT_SH      = 4;
  localparam int OFS_STATUS   = 8;
endpackage

// File: rtl/rxd_head_reg.sv
module rxd_head_reg #(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [31:0]       wdata,
  output logic [ADDR_W-1:0] head
);
  logic [63:0] head_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
    end else begin
      if (lo_we) head_q[31:0]  <= wdata;
      if (hi_we) head_q[63:32] <= wdata;
    end
  end

  assign head = head_q[ADDR_W-1:0];
endmodule

// File: rtl/rxd_stat_pack.sv
module rxd_stat_pack #(
  parameter int DATA_W = 64
) (
  input  logic [rxd_pkg::LEN_W-1:0] len,
  input  logic                      sof,
  input  logic                      eof,
  input  logic                      intr,
  output logic [DATA_W-1:0]         word
);
  import rxd_pkg::*;

  always_comb begin
    word = '0;
    word[LEN_W-1:0]   = len;
    word[ST_SOF_BIT]  = sof;
    word[ST_EOF_BIT]  = eof;
    word[ST_IRQ_BIT]  = intr;
    word[ST_DONE_BIT] = 1'b1;
  end
endmodule

// File: rtl/rxd_chan.sv
module rxd_chan #(
  parameter int ADDR_W   = 64,
  parameter int DATA_W   = 64,
  parameter int MAX_BUFS = 15,
  parameter int BUFS_W   = $clog2(MAX_BUFS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              head_lo_we,
  input  logic              head_hi_we,
  input  logic [31:0]       head_wdata,
  input  logic [BUFS_W-1:0] cfg_bufs,
  input  logic              cfg_eof_irq_only,
  input  logic              ch_activate,
  input  logic              ch_reload,
  input  logic              ch_stop,
  output logic              ch_active,
  output logic              ch_stalled,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              irq
);
  import rxd_pkg::*;

  localparam int BEAT_SH = $clog2(DATA_W / 8);
  localparam int CAP_W   = LEN_W - BEAT_SH;

  rxd_state_e        st;
  logic [ADDR_W-1:0] head, dcb, buf_ptr;
  logic [CAP_W-1:0]  cap_q, beats;
  logic              info_irq;
  logic [BUFS_W-1:0] buf_i, n_bufs;
  logic [DATA_W-1:0] beat_q, stat_word;
  logic              beat_eof, buf_sof, buf_eof, mid_frame;
  logic              rd_pend, stop_pend, irq_q, stat_intr, edge_stop;
  logic [ADDR_W-1:0] slot_addr;
  logic              rd_state;

  rxd_head_reg #(.ADDR_W(ADDR_W)) i_head (
    .clk(clk), .rst(rst), .lo_we(head_lo_we), .hi_we(head_hi_we),
    .wdata(head_wdata), .head(head)
  );

  assign stat_intr = info_irq && (buf_eof || !cfg_eof_irq_only);

  rxd_stat_pack #(.DATA_W(DATA_W)) i_pack (
    .len({beats, {BEAT_SH{1'b0}}}), .sof(buf_sof), .eof(buf_eof),
    .intr(stat_intr), .word(stat_word)
  );

  always_comb begin
    if (cfg_bufs == '0)              n_bufs = BUFS_W'(1);
    else if (cfg_bufs > BUFS_W'(MAX_BUFS)) n_bufs = BUFS_W'(MAX_BUFS);
    else                             n_bufs = cfg_bufs;
  end

  assign slot_addr = dcb + ADDR_W'(OFS_SLOT0) + (ADDR_W'(buf_i) << SLOT_SH);
  assign edge_stop = stop_pend && (beats == '0) && !mid_frame;
  assign rd_state  = (st == ST_RINFO) || (st == ST_RPTR) || (st == ST_RNEXT);

  always_comb begin
    mem_req   = (rd_state && !rd_pend) || (st == ST_WR) || (st == ST_STAT);
    mem_we    = (st == ST_WR) || (st == ST_STAT);
    mem_wdata = (st == ST_WR) ? beat_q : stat_word;
    case (st)
      ST_RINFO: mem_addr = dcb + ADDR_W'(OFS_INFO);
      ST_RPTR:  mem_addr = slot_addr;
      ST_WR:    mem_addr = buf_ptr + (ADDR_W'(beats) << BEAT_SH);
      ST_STAT:  mem_addr = slot_addr + ADDR_W'(OFS_STATUS);
      default:  mem_addr = dcb;
    endcase
  end

  assign in_ready   = (st == ST_DATA) && !edge_stop && (beats != cap_q);
  assign ch_active  = (st != ST_IDLE);
  assign ch_stalled = (st == ST_STALL);
  assign irq        = irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      dcb       <= '0;
      buf_ptr   <= '0;
      cap_q     <= '0;
      info_irq  <= 1'b0;
      beats     <= '0;
      buf_i     <= '0;
      beat_q    <= '0;
      beat_eof  <= 1'b0;
      buf_sof   <= 1'b0;
      buf_eof   <= 1'b0;
      mid_frame <= 1'b0;
      rd_pend   <= 1'b0;
      stop_pend <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (ch_stop && st != ST_IDLE) stop_pend <= 1'b1;
      case (st)
        ST_IDLE: begin
          stop_pend <= 1'b0;
          mid_frame <= 1'b0;
          if (ch_activate) begin
            dcb   <= head;
            buf_i <= '0;
            st    <= ST_RINFO;
          end
        end
        ST_RINFO, ST_RPTR, ST_RNEXT: begin
          if (!rd_pend) begin
            if (mem_gnt) rd_pend <= 1'b1;
          end else if (mem_rvalid) begin
            rd_pend <= 1'b0;
            if (st == ST_RINFO) begin
              cap_q    <= mem_rdata[LEN_W-1:BEAT_SH];
              info_irq <= mem_rdata[INFO_IRQ_BIT];
              st       <= ST_RPTR;
            end else if (st == ST_RPTR) begin
              buf_ptr <= mem_rdata[ADDR_W-1:0];
              beats   <= '0;
              buf_sof <= 1'b0;
              buf_eof <= 1'b0;
              st      <= ST_DATA;
            end else if (mem_rdata[0]) begin
              st <= ST_STALL;
            end else begin
              dcb   <= mem_rdata[ADDR_W-1:0];
              buf_i <= '0;
              st    <= ST_RINFO;
            end
          end
        end
        ST_DATA: begin
          if (edge_stop) begin
            st <= ST_IDLE;
          end else if (beats == cap_q) begin
            st <= ST_STAT;
          end else if (in_valid) begin
            beat_q   <= in_data;
            beat_eof <= in_eof;
            if (beats == '0) buf_sof <= in_sof;
            st <= ST_WR;
          end
        end
        ST_WR: begin
          if (mem_gnt) begin
            beats     <= beats + 1'b1;
            mid_frame <= !beat_eof;
            if (beat_eof) begin
              buf_eof <= 1'b1;
              st      <= ST_STAT;
            end else begin
              st <= ST_DATA;
            end
          end
        end
        ST_STAT: begin
          if (mem_gnt) begin
            irq_q <= stat_intr;
            if (buf_i == n_bufs - 1'b1) begin
              st <= ST_RNEXT;
            end else begin
              buf_i <= buf_i + 1'b1;
              st    <= ST_RPTR;
            end
          end
        end
        ST_STALL: begin
          if (stop_pend)      st <= ST_IDLE;
          else if (ch_reload) st <= ST_RNEXT;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxd_chan_chk.sv
module rxd_chan_chk #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              ch_active,
  input logic              ch_stalled,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_gnt,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              irq
);
  // R3
  beat_write_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (mem_req && mem_we && mem_wdata == $past(in_data)));

  // R7
  stall_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ch_stalled |-> (!mem_req && !in_ready));

  // R8
  resume_read_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ch_stalled) |-> ((mem_req && !mem_we && mem_addr[3:0] == 4'd0) || !ch_active));

  // R10
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(mem_req && mem_we && mem_gnt && mem_wdata[18] && mem_wdata[19]));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !ch_active |-> (!mem_req && !in_ready && !irq));
endmodule

bind rxd_chan rxd_chan_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_rxd_chan.sv
`timescale 1ns/1ps
module test_rxd_chan;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        head_lo_we = 0, head_hi_we = 0;
  logic [31:0] head_wdata = '0;
  logic [3:0]  cfg_bufs = 4'd2;
  logic        cfg_eof_irq_only = 1'b1;
  logic        ch_activate = 0, ch_reload = 0, ch_stop = 0;
  logic        ch_active, ch_stalled;
  logic        in_valid = 0, in_sof = 0, in_eof = 0;
  logic [63:0] in_data = '0;
  logic        in_ready;
  logic        mem_req, mem_we, mem_gnt, mem_rvalid;
  logic [63:0] mem_addr, mem_wdata, mem_rdata;
  logic        irq;

  logic [63:0] mem [0:511];
  logic        tick = 1'b0, gnt_all = 1'b1, rv = 1'b0, abort = 1'b0;
  logic [63:0] rd = '0;
  int          checks = 0, fails = 0, irq_cnt = 0, cyc = 0;

  always #4 clk = ~clk;

  rxd_chan i_rxd_chan (
    .clk(clk), .rst(rst), .head_lo_we(head_lo_we), .head_hi_we(head_hi_we),
    .head_wdata(head_wdata), .cfg_bufs(cfg_bufs), .cfg_eof_irq_only(cfg_eof_irq_only),
    .ch_activate(ch_activate), .ch_reload(ch_reload), .ch_stop(ch_stop),
    .ch_active(ch_active), .ch_stalled(ch_stalled), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .irq(irq)
  );

  assign mem_gnt    = mem_req && (gnt_all || tick);
  assign mem_rvalid = rv;
  assign mem_rdata  = rd;

  always @(posedge clk) begin
    tick <= ~tick;
    rv   <= 1'b0;
    if (mem_req && mem_gnt) begin
      if (mem_we) mem[mem_addr[11:3]] <= mem_wdata;
      else begin
        rd <= mem[mem_addr[11:3]];
        rv <= 1'b1;
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (irq) irq_cnt++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: run did not finish (act=%0d exp<=100000)", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [63:0] beat(int f, int k);
    return 64'hA5A5_0000_0000_0000 | (64'(f) << 16) | 64'(k);
  endfunction

  function automatic logic [63:0] stw(int len, bit s, bit e, bit i);
    return 64'(len) | (64'(s) << 16) | (64'(e) << 17) | (64'(i) << 18) | (64'd1 << 19);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 512; i++) mem[i] = '0;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic set_head(input logic [31:0] lo, input logic [31:0] hi);
    @(negedge clk); head_wdata = lo; head_lo_we = 1;
    @(negedge clk); head_lo_we = 0; head_wdata = hi; head_hi_we = 1;
    @(negedge clk); head_hi_we = 0;
  endtask

  task automatic send_frame(input int f, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1; in_data = beat(f, k); in_sof = (k == 0); in_eof = (k == n - 1);
      while (!in_ready && !abort) @(negedge clk);
      if (abort) break;
    end
    if (!abort) @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0;
  endtask

  task automatic wait_done(input int idx);
    for (int t = 0; t < 3000 && !mem[idx][19]; t++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_stall();
    for (int t = 0; t < 3000 && !ch_stalled; t++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int t = 0; t < 3000 && ch_active; t++) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 mem_req in reset", 64'(mem_req), 0);
    chk("R1 in_ready in reset", 64'(in_ready), 0);
    @(negedge clk); rst = 0;
    @(negedge clk);
    chk("R1 idle after reset", {61'b0, ch_active, irq, mem_req}, 0);
  endtask

  task automatic t_head();
    bit seen = 0;
    clear_mem();
    set_head(32'h0000_0040, 32'h0000_0005);
    pulse(ch_activate);
    for (int t = 0; t < 20 && !seen; t++) begin
      if (mem_req) seen = 1; else @(negedge clk);
    end
    chk("R2 first request address", mem_addr, 64'h0000_0005_0000_0048);
    chk("R2 first request is read", 64'(mem_we), 0);
    pulse(ch_stop);
    wait_idle();
    repeat (2) @(negedge clk);
    chk("R11 idle after stop", {62'b0, ch_active, mem_req}, 0);
  endtask

  task automatic t_single();
    clear_mem();
    mem[0] = 64'h1; mem[1] = 64'h40040; mem[2] = 64'h400; mem[4] = 64'h440;
    cfg_bufs = 2; cfg_eof_irq_only = 1; gnt_all = 0;
    set_head(32'h0, 32'h0);
    pulse(ch_activate);
    send_frame(1, 3);
    wait_done(3);
    for (int k = 0; k < 3; k++) chk("R3 beat stored in buffer", mem[128 + k], beat(1, k));
    chk("R4 completion word single frame", mem[3], stw(24, 1, 1, 1));
    chk("R10 irq after frame end", 64'(irq_cnt), 1);
  endtask

  task automatic t_span();
    int reqs = 0, rdy = 0;
    fork send_frame(2, 10); join_none
    wait_stall();
    chk("R7 stalled at chain end", 64'(ch_stalled), 1);
    chk("R5 first part status", mem[5], stw(64, 1, 0, 0));
    for (int k = 0; k < 8; k++) chk("R5 first part data", mem[136 + k], beat(2, k));
    chk("R10 no irq without frame end", 64'(irq_cnt), 1);
    for (int t = 0; t < 20; t++) begin
      @(negedge clk);
      if (mem_req) reqs++;
      if (in_ready) rdy++;
    end
    chk("R7 no memory request while stalled", 64'(reqs), 0);
    chk("R9 input held off while stalled", 64'(rdy), 0);
    pulse(ch_reload);
    repeat (12) @(negedge clk);
    chk("R8 reload on terminated link stays stalled", 64'(ch_stalled), 1);
    mem[32] = 64'h1; mem[33] = 64'h40040; mem[34] = 64'h800; mem[36] = 64'h840;
    mem[0] = 64'h100;
    pulse(ch_reload);
    wait_done(35);
    chk("R8 resumed into appended descriptor", mem[35], stw(16, 0, 1, 1));
    chk("R9 held beat 8 not lost", mem[256], beat(2, 8));
    chk("R9 held beat 9 not lost", mem[257], beat(2, 9));
    chk("R10 irq count after tail", 64'(irq_cnt), 2);
  endtask

  task automatic t_allirq();
    cfg_eof_irq_only = 0;
    fork send_frame(3, 9); join_none
    wait_done(37);
    chk("R10 interrupt bit without frame end", mem[37], stw(64, 1, 0, 1));
    chk("R10 irq count all-buffer mode", 64'(irq_cnt), 3);
    wait_stall();
    chk("R6 link read after last slot", 64'(ch_stalled), 1);
    pulse(ch_stop);
    wait_idle();
    abort = 1;
    repeat (3) @(negedge clk);
    chk("R11 stop from stall", {62'b0, ch_active, in_ready}, 0);
    abort = 0;
    cfg_eof_irq_only = 1;
  endtask

  task automatic t_bufcount();
    clear_mem();
    mem[0] = 64'h1; mem[1] = 64'h40040; mem[2] = 64'h400; mem[4] = 64'h440;
    cfg_bufs = 1; gnt_all = 1;
    pulse(ch_activate);
    send_frame(4, 1);
    wait_stall();
    chk("R4 one-beat completion word", mem[3], stw(8, 1, 1, 1));
    chk("R6 second slot untouched with one slot", mem[5], 0);
    chk("R6 stalled after single slot", 64'(ch_stalled), 1);
    pulse(ch_stop);
    wait_idle();
  endtask

  initial begin
    t_reset();
    t_head();
    t_single();
    t_span();
    t_allirq();
    t_bufcount();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule